// File: doc/BRIEF.md
# Dual-Channel Switch Command Register File

This block sits behind a serial receiver and turns each completed 16-bit command frame into updates of a small control map for two power output channels. Each frame carries a 3-bit command code in bits 10:8 and a data byte in bits 7:0. Four command codes are decoded. The output-control command sets both channel enables and both current-sense enables at once. Two shared configuration commands use data bit 7 to choose the channel they write: one sets the over-current thresholds and the other sets the timing and disable options. The status command changes no state. It only picks which register image the next 8-bit response byte shows.

The receiver raises `frame_valid` when a frame is complete, for example on chip-select release, and holds `frame_word` steady while `frame_valid` is high. The block acts once on each rising edge of `frame_valid`, whatever the length of the high phase. It has no back-pressure: it accepts every frame in the cycle after the rise is seen, and `frame_valid` must fall for at least one clock before the next frame. A control write with data bit 7 set sends a one-cycle feed pulse to an external watchdog timer when `wdog_enable` is high.

Top module: `dual_switch_regs`

## Requirements
- R1: After reset, every output is 0: both channels off, sense disabled, every code 000, every disable flag clear, no feed pulse, response byte 0x00.
- R2: On command 001, `ch_on[0]` takes data bit 0, `sense_en[0]` takes bit 1, `ch_on[1]` takes bit 2 and `sense_en[1]` takes bit 3. The new values are visible after the clock edge that detects the frame.
- R3: `sense_sum` is 1 exactly when both sense enables are 1.
- R4: Command 010 writes only the channel chosen by data bit 7 (0 selects channel 0, 1 selects channel 1). Bits 2:0 go to that channel's 3-bit slice of `ocl_code` (channel n at bits 3n+2:3n), and bit 3 goes to `och_sel[n]`. The other channel is unchanged.
- R5: Command 011 writes only the channel chosen by data bit 7. Bits 1:0 go to `blank_code` bits 2n+1:2n, bit 2 goes to `ocl_to_dis[n]` and bit 3 goes to `ol_dis[n]`. The other channel is unchanged.
- R6: Command 000 leaves every register output unchanged. Data bits 2:0 (selector) and bit 7 (channel) choose the response image, which follows the live register values:
  - selector 0 gives {000, sense_sum, sense_en[1], ch_on[1], sense_en[0], ch_on[0]};
  - selector 1 gives {0000, och_sel[ch], ocl slice[ch]};
  - selector 2 gives {0000, ol_dis[ch], ocl_to_dis[ch], blank slice[ch]};
  - selectors 3 to 7 give 0x00.
- R7: `wdog_feed` is high for exactly one cycle after a command-001 frame with data bit 7 = 1 while `wdog_enable` = 1. It never rises otherwise.
- R8: Command codes 100 to 111 change nothing, including the response selection. Frame bits 15:11 are ignored.
- R9: A frame takes effect once per rising edge of `frame_valid`. Holding `frame_valid` high repeats no write and no feed pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wdog_enable | input | 1 | Allows feed pulses |
| frame_valid | input | 1 | Frame-complete strobe, acted on at its rising edge |
| frame_word | input | 16 | Received frame: command in 10:8, data in 7:0 |
| ch_on | output | 2 | Channel on/off per channel |
| sense_en | output | 2 | Current-sense enable per channel |
| sense_sum | output | 1 | Both sense enables active |
| ocl_code | output | 6 | Low over-current threshold code, 3 bits per channel |
| och_sel | output | 2 | High over-current level select per channel |
| blank_code | output | 4 | Blanking-time code, 2 bits per channel |
| ocl_to_dis | output | 2 | Over-current-low timeout disable per channel |
| ol_dis | output | 2 | Open-load detection disable per channel |
| wdog_feed | output | 1 | One-cycle watchdog feed pulse |
| resp_byte | output | 8 | Read-back byte for the next response |

## Verification
The assertions assume the following about the inputs:
- `frame_word` is stable during every cycle in which `frame_valid` is high.
- `frame_valid` is low for at least one clock between frames.
- `frame_valid` and `wdog_enable` are synchronous to `clk` and low during reset.

The stimulus keeps to these rules. It drives a new word only in the cycle in which it raises `frame_valid`, holds the strobe high for one to three cycles, and always drops it for at least one cycle before the next frame. The random frames draw from all eight command codes and all bit patterns in the unused upper bits, so the ignored codes and the ignored bits are exercised.

// File: rtl/dsw_pkg.sv
package dsw_pkg;
  localparam int FRAME_W  = 16;
  localparam int ADDR_LSB = 8;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 8;
  localparam int NUM_CH   = 2;
  localparam int OCL_W    = 3;
  localparam int BLK_W    = 2;
  localparam int SEL_W    = 3;
  localparam int CH_BIT   = 7;
  localparam int CH_W     = $clog2(NUM_CH);

  typedef enum logic [ADDR_W-1:0] {
    CMD_STATUS = 3'd0,
    CMD_OUTCTL = 3'd1,
    CMD_OVRCUR = 3'd2,
    CMD_TIMING = 3'd3
  } cmd_e;

  typedef enum logic [SEL_W-1:0] {
    VIEW_CTRL  = 3'd0,
    VIEW_OVRC  = 3'd1,
    VIEW_TIME  = 3'd2
  } view_e;

  typedef struct packed {
    logic [OCL_W-1:0] ocl;
    logic             och;
    logic [BLK_W-1:0] blk;
    logic             todis;
    logic             oldis;
  } chan_cfg_t;
endpackage

// File: rtl/dsw_frame_decoder.sv
module dsw_frame_decoder
  import dsw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_valid,
  input  logic [FRAME_W-1:0] frame_word,
  output logic               wr_status,
  output logic               wr_outctl,
  output logic               wr_ovrcur,
  output logic               wr_timing,
  output logic [DATA_W-1:0]  cmd_data
);
  logic              fv_q;
  logic              take;
  logic [ADDR_W-1:0] addr;
  logic              unused_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fv_q <= 1'b0;
    else        fv_q <= frame_valid;
  end

  assign take      = frame_valid & ~fv_q;
  assign addr      = frame_word[ADDR_LSB +: ADDR_W];
  assign cmd_data  = frame_word[DATA_W-1:0];
  assign unused_hi = ^frame_word[FRAME_W-1:ADDR_LSB+ADDR_W];

  always_comb begin
    wr_status = 1'b0;
    wr_outctl = 1'b0;
    wr_ovrcur = 1'b0;
    wr_timing = 1'b0;
    if (take) begin
      case (addr)
        CMD_STATUS: wr_status = 1'b1;
        CMD_OUTCTL: wr_outctl = 1'b1;
        CMD_OVRCUR: wr_ovrcur = 1'b1;
        CMD_TIMING: wr_timing = 1'b1;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/dsw_out_ctl.sv
module dsw_out_ctl
  import dsw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_outctl,
  input  logic              wdog_enable,
  input  logic [DATA_W-1:0] cmd_data,
  output logic [NUM_CH-1:0] ch_on,
  output logic [NUM_CH-1:0] sense_en,
  output logic              wdog_feed
);
  logic unused_mid;
  assign unused_mid = ^cmd_data[CH_BIT-1:2*NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ch_on[g]    <= 1'b0;
        sense_en[g] <= 1'b0;
      end else if (wr_outctl) begin
        ch_on[g]    <= cmd_data[2*g];
        sense_en[g] <= cmd_data[2*g+1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wdog_feed <= 1'b0;
    else        wdog_feed <= wr_outctl & cmd_data[CH_BIT] & wdog_enable;
  end
endmodule

// File: rtl/dsw_chan_bank.sv
module dsw_chan_bank
  import dsw_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_ovrcur,
  input  logic                         wr_timing,
  input  logic [DATA_W-1:0]            cmd_data,
  output chan_cfg_t [NUM_CH-1:0]       cfg
);
  logic [CH_W-1:0] ch_pick;
  logic            unused_mid;

  assign ch_pick    = cmd_data[CH_BIT -: CH_W];
  assign unused_mid = ^cmd_data[CH_BIT-CH_W:4];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign hit = (ch_pick == CH_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg[g] <= '0;
      end else begin
        if (wr_ovrcur && hit) begin
          cfg[g].ocl <= cmd_data[OCL_W-1:0];
          cfg[g].och <= cmd_data[3];
        end
        if (wr_timing && hit) begin
          cfg[g].blk   <= cmd_data[BLK_W-1:0];
          cfg[g].todis <= cmd_data[2];
          cfg[g].oldis <= cmd_data[3];
        end
      end
    end
  end
endmodule

// File: rtl/dsw_readback.sv
module dsw_readback
  import dsw_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_status,
  input  logic [DATA_W-1:0]      cmd_data,
  input  logic [NUM_CH-1:0]      ch_on,
  input  logic [NUM_CH-1:0]      sense_en,
  input  logic                   sense_sum,
  input  chan_cfg_t [NUM_CH-1:0] cfg,
  output logic [DATA_W-1:0]      resp_byte
);
  logic [SEL_W-1:0] view_q;
  logic [CH_W-1:0]  ch_q;
  chan_cfg_t        pick;
  logic             unused_mid;

  assign unused_mid = ^cmd_data[CH_BIT-CH_W:SEL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      view_q <= '0;
      ch_q   <= '0;
    end else if (wr_status) begin
      view_q <= cmd_data[SEL_W-1:0];
      ch_q   <= cmd_data[CH_BIT -: CH_W];
    end
  end

  assign pick = cfg[ch_q];

  always_comb begin
    resp_byte = '0;
    case (view_q)
      VIEW_CTRL: resp_byte = {3'b000, sense_sum, sense_en[1], ch_on[1],
                              sense_en[0], ch_on[0]};
      VIEW_OVRC: resp_byte = {4'b0000, pick.och, pick.ocl};
      VIEW_TIME: resp_byte = {4'b0000, pick.oldis, pick.todis, pick.blk};
      default:   resp_byte = '0;
    endcase
  end
endmodule

// File: rtl/dual_switch_regs.sv
module dual_switch_regs
  import dsw_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wdog_enable,
  input  logic                      frame_valid,
  input  logic [FRAME_W-1:0]        frame_word,
  output logic [NUM_CH-1:0]         ch_on,
  output logic [NUM_CH-1:0]         sense_en,
  output logic                      sense_sum,
  output logic [NUM_CH*OCL_W-1:0]   ocl_code,
  output logic [NUM_CH-1:0]         och_sel,
  output logic [NUM_CH*BLK_W-1:0]   blank_code,
  output logic [NUM_CH-1:0]         ocl_to_dis,
  output logic [NUM_CH-1:0]         ol_dis,
  output logic                      wdog_feed,
  output logic [DATA_W-1:0]         resp_byte
);
  logic                   wr_status, wr_outctl, wr_ovrcur, wr_timing;
  logic [DATA_W-1:0]      cmd_data;
  chan_cfg_t [NUM_CH-1:0] cfg;

  dsw_frame_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_word(frame_word),
    .wr_status(wr_status), .wr_outctl(wr_outctl), .wr_ovrcur(wr_ovrcur),
    .wr_timing(wr_timing), .cmd_data(cmd_data)
  );

  dsw_out_ctl u_out (
    .clk(clk), .rst_n(rst_n), .wr_outctl(wr_outctl), .wdog_enable(wdog_enable),
    .cmd_data(cmd_data), .ch_on(ch_on), .sense_en(sense_en), .wdog_feed(wdog_feed)
  );

  dsw_chan_bank u_bank (
    .clk(clk), .rst_n(rst_n), .wr_ovrcur(wr_ovrcur), .wr_timing(wr_timing),
    .cmd_data(cmd_data), .cfg(cfg)
  );

  assign sense_sum = &sense_en;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_flat
    assign ocl_code[g*OCL_W +: OCL_W]   = cfg[g].ocl;
    assign och_sel[g]                   = cfg[g].och;
    assign blank_code[g*BLK_W +: BLK_W] = cfg[g].blk;
    assign ocl_to_dis[g]                = cfg[g].todis;
    assign ol_dis[g]                    = cfg[g].oldis;
  end

  dsw_readback u_rb (
    .clk(clk), .rst_n(rst_n), .wr_status(wr_status), .cmd_data(cmd_data),
    .ch_on(ch_on), .sense_en(sense_en), .sense_sum(sense_sum), .cfg(cfg),
    .resp_byte(resp_byte)
  );
endmodule

// File: rtl/dsw_checker.sv
module dsw_checker
  import dsw_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wdog_enable,
  input logic                    frame_valid,
  input logic [FRAME_W-1:0]      frame_word,
  input logic [NUM_CH-1:0]       ch_on,
  input logic [NUM_CH-1:0]       sense_en,
  input logic [NUM_CH*OCL_W-1:0] ocl_code,
  input logic [NUM_CH-1:0]       och_sel,
  input logic [NUM_CH*BLK_W-1:0] blank_code,
  input logic [NUM_CH-1:0]       ocl_to_dis,
  input logic [NUM_CH-1:0]       ol_dis,
  input logic                    wdog_feed
);
  // R2
  outctl_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && !$past(frame_valid) && frame_word[10:8] == 3'd1)
    |=> (ch_on == {$past(frame_word[2]), $past(frame_word[0])}) &&
        (sense_en == {$past(frame_word[3]), $past(frame_word[1])}));

  // R6
  status_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && !$past(frame_valid) && frame_word[10:8] == 3'd0)
    |=> $stable(ch_on) && $stable(sense_en) && $stable(ocl_code) && $stable(och_sel)
        && $stable(blank_code) && $stable(ocl_to_dis) && $stable(ol_dis));

  // R8
  bad_cmd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && !$past(frame_valid) && frame_word[10])
    |=> $stable(ch_on) && $stable(sense_en) && $stable(ocl_code) && $stable(och_sel)
        && $stable(blank_code) && $stable(ocl_to_dis) && $stable(ol_dis));

  // R7
  feed_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_feed |-> $past(frame_valid) && !$past(frame_valid, 2) &&
                  $past(frame_word[10:8]) == 3'd1 && $past(frame_word[7]) &&
                  $past(wdog_enable));

  // R7
  feed_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_feed |=> !wdog_feed);

  // R9
  edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ch_on) || !$stable(ocl_code) || !$stable(blank_code))
    |-> $past(frame_valid) && !$past(frame_valid, 2));
endmodule

bind dual_switch_regs dsw_checker u_chk (.*);

// File: tb/tb_dual_switch_regs.sv
module tb_dual_switch_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wdog_enable = 1'b0;
  logic        frame_valid = 1'b0;
  logic [15:0] frame_word = '0;
  logic [1:0]  ch_on, sense_en, och_sel, ocl_to_dis, ol_dis;
  logic        sense_sum, wdog_feed;
  logic [5:0]  ocl_code;
  logic [3:0]  blank_code;
  logic [7:0]  resp_byte;

  int checks = 0;
  int fails  = 0;

  // bench model
  logic [1:0] m_on, m_sns, m_och, m_todis, m_oldis;
  logic [5:0] m_ocl;
  logic [3:0] m_blk;
  logic [2:0] m_sel;
  logic       m_ch;
  logic       m_feed;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_switch_regs dut (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_resp();
    logic [7:0] r;
    case (m_sel)
      3'd0: r = {3'b000, &m_sns, m_sns[1], m_on[1], m_sns[0], m_on[0]};
      3'd1: r = {4'b0, m_och[m_ch], m_ocl[3*m_ch +: 3]};
      3'd2: r = {4'b0, m_oldis[m_ch], m_todis[m_ch], m_blk[2*m_ch +: 2]};
      default: r = 8'h00;
    endcase
    return r;
  endfunction

  task automatic model_apply(input logic [15:0] w);
    logic [7:0] d;
    d = w[7:0];
    m_feed = 1'b0;
    case (w[10:8])
      3'd0: begin m_sel = d[2:0]; m_ch = d[7]; end
      3'd1: begin
        m_on  = {d[2], d[0]};
        m_sns = {d[3], d[1]};
        m_feed = d[7] & wdog_enable;
      end
      3'd2: begin m_ocl[3*d[7] +: 3] = d[2:0]; m_och[d[7]] = d[3]; end
      3'd3: begin
        m_blk[2*d[7] +: 2] = d[1:0];
        m_todis[d[7]] = d[2];
        m_oldis[d[7]] = d[3];
      end
      default: ;
    endcase
  endtask

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return "R6";
      3'd1: return "R2";
      3'd2: return "R4";
      3'd3: return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic check_state(input string req);
    logic [27:0] act, exp;
    act = {ch_on, sense_en, ocl_code, och_sel, blank_code, ocl_to_dis, ol_dis, resp_byte};
    exp = {m_on, m_sns, m_ocl, m_och, m_blk, m_todis, m_oldis, exp_resp()};
    check(act === exp, req, 64'(act), 64'(exp));
    check(sense_sum === (&m_sns), "R3", 64'(sense_sum), 64'(&m_sns));
  endtask

  task automatic send(input logic [15:0] w, input int hold, input logic wen);
    @(negedge clk);
    wdog_enable = wen;
    frame_word  = w;
    frame_valid = 1'b1;
    model_apply(w);
    @(negedge clk);
    check(wdog_feed === m_feed, "R7", 64'(wdog_feed), 64'(m_feed));
    check_state(tag_of(w[10:8]));
    for (int i = 1; i < hold; i++) begin
      @(negedge clk);
      check(wdog_feed === 1'b0, "R9", 64'(wdog_feed), 64'd0);
      check_state("R9");
    end
    frame_valid = 1'b0;
    @(negedge clk);
    check(wdog_feed === 1'b0, "R7", 64'(wdog_feed), 64'd0);
    check_state(tag_of(w[10:8]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_on = '0; m_sns = '0; m_och = '0; m_todis = '0; m_oldis = '0;
    m_ocl = '0; m_blk = '0; m_sel = '0; m_ch = 1'b0; m_feed = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(wdog_feed === 1'b0, "R1", 64'(wdog_feed), 64'd0);
    check_state("R1");

    // R2 / R3 directed
    send(16'h010F, 1, 1'b0);
    send(16'h0105, 2, 1'b0);
    // R4 channel 1 only, then channel 0
    send(16'h028D, 1, 1'b0);
    send(16'h0203, 1, 1'b0);
    // R5 both channels
    send(16'h038E, 1, 1'b0);
    send(16'h0305, 3, 1'b0);
    // R6 read-back views
    send(16'h0081, 1, 1'b0);
    send(16'h0002, 1, 1'b0);
    send(16'h0082, 2, 1'b0);
    send(16'h0005, 1, 1'b0);
    send(16'h0000, 1, 1'b0);
    // R7 feed enabled, disabled, and on another command
    send(16'h018A, 1, 1'b1);
    send(16'h018A, 3, 1'b0);
    send(16'h0280, 1, 1'b1);
    // R8 ignored commands and upper bits
    send(16'h04FF, 1, 1'b1);
    send(16'h07FF, 2, 1'b1);
    send(16'hF9F0, 1, 1'b0);
    // R9 long hold with feed
    send(16'h0183, 3, 1'b1);

    for (int n = 0; n < 400; n++) begin
      logic [15:0] w;
      w = 16'($urandom);
      if ($urandom_range(0, 3) != 0) w[10] = 1'b0;
      send(w, int'($urandom_range(1, 3)), 1'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule